// File: doc/BRIEF.md
# Data-Link Message Frame Transmitter

This block turns one stored data-link message into a serial frame and hands it to a host framer one octet at a time. Software writes the message into an 82-byte buffer, picks the message length (76 or 82 bytes) with a level input, and starts transmission through a single 8-bit control/status register. The frame begins with a 0x7E flag. The message follows, then a 16-bit check sequence over the message. Zero bits are inserted after every run of five ones in the message and check bits. A closing 0x7E flag ends the frame, and the last octet is padded with flag-pattern bits.

The stuffed bit stream is collected into octets. The host framer has two overhead byte fields, and a configuration input selects one of them as the carrier. Each strobe of the selected field's slot takes the octet currently on offer, and the next octet is then built at one bit per clock. When no frame is in progress the offered octet is a 0x7E flag. The unselected field always shows 0x7E and its strobe has no effect. A busy bit shows when a frame is in flight. A completion status bit clears when the register is read, and together with an enable bit it drives an interrupt line. The selected field's strobes must be at least 10 clock cycles apart.

Top module: `dlmsg_tx`

## Requirements
- R1: A frame is started only by a register write with bit 3 = 1 while the stored bit 3 is 0 and the block is not busy. Writing 1 while bit 3 already reads 1, or any start write while busy, starts nothing.
- R2: Register bit 2 (busy, read-only) reads 1 from the cycle after the start write until the strobe that takes the octet holding the last bit of the closing flag, and reads 0 after it.
- R3: Register layout is: bit 3 start (read/write), bit 2 busy, bit 1 interrupt enable (read/write), bit 0 completion status. Bits 7..4 read 0. All bits read 0 after reset.
- R4: Status bit 0 sets when the frame completes and clears on a register read. A completion in the same cycle as a read leaves it set. `irq` is 1 exactly when status and enable are both 1.
- R5: After five consecutive 1 bits among the message and check-sequence bits, a 0 bit is inserted. This includes a run that ends on the last check bit, so no six 1s occur between the flags.
- R6: The check sequence uses x^16+x^12+x^5+1, starts from 0xFFFF, and is computed over the message bits taken LSB first. Its ones complement is sent low-order bit first, right after the last message bit.
- R7: The message length is 76 bytes when `msg_long` = 0 and 82 bytes when `msg_long` = 1, sampled at the start write.
- R8: Octets are formed LSB first from the bit stream. While idle each octet is 0x7E. After a start from idle, the first strobe takes the idle flag, the second takes the unstuffed opening flag 0x7E, and the frame body follows. The closing flag 0x7E is sent unstuffed, and the remaining bits of its last octet are bit p of 0x7E for octet position p.
- R9: `field_sel` = 0 carries the frame on `slot0_byte` / `slot0_take`, and 1 carries it on `slot1_byte` / `slot1_take`. The other field's byte reads 0x7E and its strobe consumes nothing.
- R10: Message buffer writes while busy are ignored, so the frame in flight carries the bytes present at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_we | input | 1 | Message buffer write strobe |
| msg_addr | input | 7 | Message buffer byte address (0..81) |
| msg_wdata | input | 8 | Message buffer write data |
| csr_we | input | 1 | Control/status register write strobe |
| csr_re | input | 1 | Control/status register read strobe (clears status) |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| msg_long | input | 1 | Message length select: 0 = 76 bytes, 1 = 82 bytes |
| field_sel | input | 1 | Overhead field select: 0 = field 0, 1 = field 1 |
| slot0_take | input | 1 | Slot strobe of overhead field 0 |
| slot1_take | input | 1 | Slot strobe of overhead field 1 |
| slot0_byte | output | 8 | Octet offered on overhead field 0 |
| slot1_byte | output | 8 | Octet offered on overhead field 1 |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong stuffing counter or check register corrupts the octet sequence. The damage shows within one or two octets of the faulty bit, or at the latest in the octets holding the check sequence and the closing flag. A wrong byte index or length choice moves the closing flag and changes the octet count, so busy falls on a different strobe than expected. A wrong start-edge or completion state shows in the register bits on the very next cycle: busy rises without a start, fails to rise, or stays set, and status fails to set or to clear on a read.

// File: rtl/dlmsg_pkg.sv
package dlmsg_pkg;

    localparam int OCT_W     = 8;
    localparam int FCS_W     = 16;
    localparam int MSG_SHORT = 76;
    localparam int MSG_LONG  = 82;
    localparam int ADDR_W    = $clog2(MSG_LONG);
    localparam int RUN_MAX   = 5;

    localparam logic [OCT_W-1:0] FLAG_OCT  = 8'h7E;
    localparam logic [FCS_W-1:0] FCS_SEED  = 16'hFFFF;
    localparam logic [FCS_W-1:0] FCS_RPOLY = 16'h8408;

    // register bit positions
    localparam int B_START = 3;
    localparam int B_BUSY  = 2;
    localparam int B_IEN   = 1;
    localparam int B_STAT  = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DATA,
        PH_FCS,
        PH_CLOSE,
        PH_PAD
    } phase_e;

    typedef struct packed {
        logic start;
        logic busy;
        logic ien;
        logic stat;
    } csr_t;

    // one bit of the reflected check-sequence update
    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[FCS_W-1:1]} ^ (fb ? FCS_RPOLY : '0);
    endfunction

endpackage

// File: rtl/dlmsg_ctrl.sv
module dlmsg_ctrl
    import dlmsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic             csr_re,
    input  logic             wr_start,
    input  logic             wr_ien,
    input  logic             done,
    output logic [OCT_W-1:0] csr_rdata,
    output logic             busy,
    output logic             go,
    output logic             irq
);

    csr_t r;

    // rising edge of the start bit, honoured only when idle
    assign go = csr_we && wr_start && !r.start && !r.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else begin
            if (csr_we) begin
                r.start <= wr_start;
                r.ien   <= wr_ien;
            end
            if (go)
                r.busy <= 1'b1;
            else if (done)
                r.busy <= 1'b0;
            if (csr_re)
                r.stat <= 1'b0;
            if (done)
                r.stat <= 1'b1;
        end
    end

    always_comb begin
        csr_rdata          = '0;
        csr_rdata[B_START] = r.start;
        csr_rdata[B_BUSY]  = r.busy;
        csr_rdata[B_IEN]   = r.ien;
        csr_rdata[B_STAT]  = r.stat;
    end

    assign busy = r.busy;
    assign irq  = r.stat && r.ien;

endmodule

// File: rtl/dlmsg_bitgen.sv
module dlmsg_bitgen
    import dlmsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [OCT_W-1:0]  wr_data,
    input  logic              go,
    input  logic              long_sel,
    input  logic              emit,
    input  logic [2:0]        pos,
    output logic              bit_out,
    output logic              close_done,
    output logic              in_body
);

    localparam int FIDX_W = $clog2(FCS_W);

    logic [OCT_W-1:0]  mem [MSG_LONG];
    phase_e            phase;
    logic [ADDR_W-1:0] byte_idx;
    logic [2:0]        bit_idx;
    logic [FIDX_W-1:0] fidx;
    logic [2:0]        cidx;
    logic [2:0]        ones;
    logic [FCS_W-1:0]  crc;
    logic              pend;
    logic              long_q;

    logic              stuff_now;
    logic              data_bit;
    logic              at_last_byte;
    logic [FCS_W-1:0]  crc_nx;

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < MSG_LONG))
            mem[wr_addr] <= wr_data;
    end

    assign data_bit     = mem[byte_idx][bit_idx];
    assign stuff_now    = (phase == PH_DATA || phase == PH_FCS || phase == PH_CLOSE)
                          && (32'(ones) == RUN_MAX);
    assign at_last_byte = long_q ? (byte_idx == ADDR_W'(MSG_LONG - 1))
                                 : (byte_idx == ADDR_W'(MSG_SHORT - 1));
    assign crc_nx       = fcs_step(crc, data_bit);
    assign in_body      = (phase == PH_DATA) || (phase == PH_FCS);
    assign close_done   = emit && (phase == PH_CLOSE) && !stuff_now && (cidx == 3'd7);

    always_comb begin
        unique case (phase)
            PH_DATA:  bit_out = stuff_now ? 1'b0 : data_bit;
            PH_FCS:   bit_out = stuff_now ? 1'b0 : crc[fidx];
            PH_CLOSE: bit_out = stuff_now ? 1'b0 : FLAG_OCT[cidx];
            default:  bit_out = FLAG_OCT[pos];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            byte_idx <= '0;
            bit_idx  <= '0;
            fidx     <= '0;
            cidx     <= '0;
            ones     <= '0;
            crc      <= FCS_SEED;
            pend     <= 1'b0;
            long_q   <= 1'b0;
        end else begin
            if (go) begin
                pend   <= 1'b1;
                long_q <= long_sel;
            end
            if (emit) begin
                unique case (phase)
                    PH_IDLE: begin
                        // the aligned flag in progress serves as the opening flag
                        if (pos == 3'd7 && pend) begin
                            phase    <= PH_DATA;
                            byte_idx <= '0;
                            bit_idx  <= '0;
                            ones     <= '0;
                            crc      <= FCS_SEED;
                            pend     <= 1'b0;
                        end
                    end
                    PH_DATA: begin
                        if (stuff_now) begin
                            ones <= '0;
                        end else begin
                            ones <= data_bit ? ones + 3'd1 : 3'd0;
                            crc  <= crc_nx;
                            if (bit_idx == 3'd7) begin
                                bit_idx <= '0;
                                if (at_last_byte) begin
                                    phase <= PH_FCS;
                                    fidx  <= '0;
                                    crc   <= ~crc_nx;
                                end else begin
                                    byte_idx <= byte_idx + 1'b1;
                                end
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                            end
                        end
                    end
                    PH_FCS: begin
                        if (stuff_now) begin
                            ones <= '0;
                        end else begin
                            ones <= crc[fidx] ? ones + 3'd1 : 3'd0;
                            if (fidx == FIDX_W'(FCS_W - 1)) begin
                                phase <= PH_CLOSE;
                                cidx  <= '0;
                            end else begin
                                fidx <= fidx + 1'b1;
                            end
                        end
                    end
                    PH_CLOSE: begin
                        if (stuff_now) begin
                            ones <= '0;
                        end else if (cidx == 3'd7) begin
                            phase <= (pos == 3'd7) ? PH_IDLE : PH_PAD;
                        end else begin
                            cidx <= cidx + 3'd1;
                        end
                    end
                    default: begin
                        if (pos == 3'd7)
                            phase <= PH_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dlmsg_packer.sv
module dlmsg_packer
    import dlmsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             close_done,
    input  logic             field_sel,
    input  logic             slot0_take,
    input  logic             slot1_take,
    output logic             emit,
    output logic [2:0]       pos,
    output logic [OCT_W-1:0] slot0_byte,
    output logic [OCT_W-1:0] slot1_byte,
    output logic             done
);

    logic [OCT_W-2:0] stage;
    logic [OCT_W-1:0] shown;
    logic             full;
    logic             shown_last;
    logic             last_pend;
    logic             take;

    assign emit = !full;
    assign take = full && (field_sel ? slot1_take : slot0_take);
    assign done = take && shown_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage      <= '0;
            shown      <= FLAG_OCT;
            full       <= 1'b0;
            pos        <= '0;
            shown_last <= 1'b0;
            last_pend  <= 1'b0;
        end else if (emit) begin
            if (pos == 3'd7) begin
                shown      <= {bit_in, stage};
                shown_last <= last_pend || close_done;
                last_pend  <= 1'b0;
                full       <= 1'b1;
                pos        <= '0;
            end else begin
                stage <= {bit_in, stage[OCT_W-2:1]};
                pos   <= pos + 3'd1;
                if (close_done)
                    last_pend <= 1'b1;
            end
        end else if (take) begin
            full       <= 1'b0;
            shown_last <= 1'b0;
        end
    end

    assign slot0_byte = field_sel ? FLAG_OCT : shown;
    assign slot1_byte = field_sel ? shown : FLAG_OCT;

endmodule

// File: rtl/dlmsg_tx.sv
module dlmsg_tx
    import dlmsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_we,
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic [OCT_W-1:0]  msg_wdata,
    input  logic              csr_we,
    input  logic              csr_re,
    input  logic [OCT_W-1:0]  csr_wdata,
    output logic [OCT_W-1:0]  csr_rdata,
    input  logic              msg_long,
    input  logic              field_sel,
    input  logic              slot0_take,
    input  logic              slot1_take,
    output logic [OCT_W-1:0]  slot0_byte,
    output logic [OCT_W-1:0]  slot1_byte,
    output logic              irq
);

    logic       busy;
    logic       go;
    logic       done;
    logic       gen_bit;
    logic       gen_emit;
    logic       gen_body;
    logic       close_done;
    logic [2:0] pos;
    logic       unused_wbits;

    assign unused_wbits = ^{csr_wdata[7:4], csr_wdata[B_BUSY], csr_wdata[B_STAT]};

    dlmsg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .csr_we    (csr_we),
        .csr_re    (csr_re),
        .wr_start  (csr_wdata[B_START]),
        .wr_ien    (csr_wdata[B_IEN]),
        .done      (done),
        .csr_rdata (csr_rdata),
        .busy      (busy),
        .go        (go),
        .irq       (irq)
    );

    dlmsg_bitgen u_bitgen (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (msg_we && !busy),
        .wr_addr    (msg_addr),
        .wr_data    (msg_wdata),
        .go         (go),
        .long_sel   (msg_long),
        .emit       (gen_emit),
        .pos        (pos),
        .bit_out    (gen_bit),
        .close_done (close_done),
        .in_body    (gen_body)
    );

    dlmsg_packer u_packer (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (gen_bit),
        .close_done (close_done),
        .field_sel  (field_sel),
        .slot0_take (slot0_take),
        .slot1_take (slot1_take),
        .emit       (gen_emit),
        .pos        (pos),
        .slot0_byte (slot0_byte),
        .slot1_byte (slot1_byte),
        .done       (done)
    );

endmodule

// File: rtl/dlmsg_tx_chk.sv
module dlmsg_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       csr_we,
    input logic       csr_re,
    input logic       wr_start,
    input logic [3:0] rd,
    input logic       irq,
    input logic       emit,
    input logic       sbit,
    input logic       body
);

    logic [2:0] run;

    always_ff @(posedge clk) begin
        if (rst)
            run <= '0;
        else if (emit)
            run <= (body && sbit) ? run + 3'd1 : 3'd0;
    end

    // R1: busy rises only after a write that raises the start bit
    assert_start_edge_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rd[2]) |-> $past(csr_we && wr_start && !rd[3]));

    // R1: rewriting 1 over a set start bit while idle starts nothing
    assert_no_rearm_R1: assert property (@(posedge clk) disable iff (rst)
        (csr_we && wr_start && rd[3] && !rd[2]) |=> !rd[2]);

    // R4: status sets only together with the end of busy
    assert_stat_on_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd[0]) |-> $fell(rd[2]));

    // R4: a read clears status unless completion coincides
    assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
        csr_re |=> (!rd[0] || $fell(rd[2])));

    // R4: no interrupt without the enable bit
    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd[1] && rd[0]));

    // R5: never a sixth consecutive one inside the body
    assert_no_six_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (emit && body && sbit) |-> (run < 3'd5));

endmodule

bind dlmsg_tx dlmsg_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .csr_we   (csr_we),
    .csr_re   (csr_re),
    .wr_start (csr_wdata[3]),
    .rd       (csr_rdata[3:0]),
    .irq      (irq),
    .emit     (gen_emit),
    .sbit     (gen_bit),
    .body     (gen_body)
);

// File: tb/dlmsg_tx_bench.sv
module dlmsg_tx_bench;

    localparam logic [7:0] FLAGV = 8'h7E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_we = 1'b0;
    logic [6:0] msg_addr = '0;
    logic [7:0] msg_wdata = '0;
    logic       csr_we = 1'b0;
    logic       csr_re = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       msg_long = 1'b0;
    logic       field_sel = 1'b0;
    logic       slot0_take = 1'b0;
    logic       slot1_take = 1'b0;
    logic [7:0] slot0_byte;
    logic [7:0] slot1_byte;
    logic       irq;

    int total = 0;
    int fails = 0;

    logic [7:0]  msg [82];
    logic        eb [1024];
    int          nb;
    int          run1;
    logic [15:0] cr;
    logic [7:0]  eo [128];
    int          no;

    always #5 clk = ~clk;

    dlmsg_tx u_dlmsg_tx (
        .clk(clk), .rst(rst), .msg_we(msg_we), .msg_addr(msg_addr), .msg_wdata(msg_wdata),
        .csr_we(csr_we), .csr_re(csr_re), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .msg_long(msg_long), .field_sel(field_sel), .slot0_take(slot0_take),
        .slot1_take(slot1_take), .slot0_byte(slot0_byte), .slot1_byte(slot1_byte), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------- reference model of the frame ----------
    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic [15:0] s;
        s = c >> 1;
        if (c[0] != b) s = s ^ 16'h8408;
        return s;
    endfunction

    task automatic put(input logic b);
        eb[nb] = b;
        nb++;
    endtask

    task automatic put_body(input logic b);
        put(b);
        if (b) begin
            run1++;
            if (run1 == 5) begin
                put(1'b0);
                run1 = 0;
            end
        end else begin
            run1 = 0;
        end
    endtask

    task automatic build(input int len);
        nb = 0; run1 = 0; cr = 16'hFFFF;
        for (int i = 0; i < 8; i++) put(FLAGV[i]);
        for (int i = 0; i < len; i++)
            for (int j = 0; j < 8; j++) begin
                put_body(msg[i][j]);
                cr = crc_upd(cr, msg[i][j]);
            end
        cr = ~cr;
        for (int k = 0; k < 16; k++) put_body(cr[k]);
        for (int i = 0; i < 8; i++) put(FLAGV[i]);
        while ((nb % 8) != 0) put(FLAGV[nb % 8]);
        no = nb / 8;
        for (int o = 0; o < no; o++)
            for (int j = 0; j < 8; j++) eo[o][j] = eb[o*8 + j];
    endtask

    // ---------- drivers ----------
    task automatic csr_wr(input logic [7:0] v);
        @(negedge clk); csr_we = 1'b1; csr_wdata = v;
        @(negedge clk); csr_we = 1'b0;
    endtask

    task automatic csr_rd(output logic [7:0] v);
        @(negedge clk); v = csr_rdata; csr_re = 1'b1;
        @(negedge clk); csr_re = 1'b0;
    endtask

    task automatic msg_wr(input int a, input logic [7:0] d);
        @(negedge clk); msg_we = 1'b1; msg_addr = 7'(a); msg_wdata = d;
        @(negedge clk); msg_we = 1'b0;
    endtask

    task automatic strobe(input logic sel, input logic rd, output logic [7:0] got);
        @(negedge clk);
        got = sel ? slot1_byte : slot0_byte;
        if (sel) slot1_take = 1'b1; else slot0_take = 1'b1;
        csr_re = rd;
        @(negedge clk);
        slot0_take = 1'b0; slot1_take = 1'b0; csr_re = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic load(input int pat);
        for (int i = 0; i < 82; i++) begin
            case (pat)
                0:       msg[i] = 8'hFF;
                1:       msg[i] = 8'(i);
                default: msg[i] = 8'((i * 37 + 11) ^ (i >> 1));
            endcase
            msg_wr(i, msg[i]);
        end
    endtask

    // sends one frame from idle; start bit must read 0 beforehand
    task automatic send_frame(input string tag, input logic lng, input logic sel, input logic ien,
                              input logic rd_last, input logic poke, input logic meddle);
        logic [7:0] got;
        logic [7:0] exp;
        int bad = 0;
        int first_bad = -1;
        logic [7:0] fa = 0, fe = 0;
        msg_long = lng; field_sel = sel;
        build(lng ? 82 : 76);
        csr_wr({4'b0, 1'b1, 1'b0, ien, 1'b0});
        msg_long = 1'b0;
        chk(tag, "busy after start (R2)", {31'b0, csr_rdata[2]}, 1);
        for (int k = 0; k <= no; k++) begin
            exp = (k == 0) ? FLAGV : eo[k-1];
            if (k == no) chk(tag, "busy before last octet (R2)", {31'b0, csr_rdata[2]}, 1);
            strobe(sel, rd_last && (k == no), got);
            if (got !== exp) begin
                bad++;
                if (first_bad < 0) begin first_bad = k; fa = got; fe = exp; end
            end
            if (poke && k == 3) begin
                chk(tag, "unselected field flag (R9)", {24'b0, sel ? slot0_byte : slot1_byte}, {24'b0, FLAGV});
                strobe(!sel, 1'b0, got);
            end
            if (meddle && k == 2) begin
                msg_wr(5, ~msg[5]);
                csr_wr({4'b0, 1'b0, 1'b0, ien, 1'b0});
                csr_wr({4'b0, 1'b1, 1'b0, ien, 1'b0});
                chk(tag, "busy kept through restart attempt (R1)", {31'b0, csr_rdata[2]}, 1);
            end
        end
        if (bad != 0)
            $display("FAIL %s octet %0d (R5 R6 R7 R8): got %0h expected %0h", tag, first_bad, fa, fe);
        total++;
        if (bad != 0) fails++;
        chk(tag, "busy clear after last octet (R2)", {31'b0, csr_rdata[2]}, 0);
        chk(tag, "status set (R4)", {31'b0, csr_rdata[0]}, 1);
        chk(tag, "irq level (R4)", {31'b0, irq}, {31'b0, ien});
    endtask

    // ---------- scenarios ----------
    task automatic t_reset;
        logic [7:0] got;
        chk("reset", "register value (R3)", {24'b0, csr_rdata}, 0);
        chk("reset", "irq (R4)", {31'b0, irq}, 0);
        chk("reset", "field0 idle flag (R8)", {24'b0, slot0_byte}, {24'b0, FLAGV});
        strobe(1'b0, 1'b0, got);
        strobe(1'b0, 1'b0, got);
        chk("reset", "idle octet after strobe (R8)", {24'b0, got}, {24'b0, FLAGV});
        chk("reset", "no busy while idle (R2)", {31'b0, csr_rdata[2]}, 0);
    endtask

    task automatic t_short_ones;
        load(0);
        send_frame("short_ones", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("short_ones", "register readback (R3)", {24'b0, csr_rdata}, 32'h0B);
    endtask

    task automatic t_read_clear;
        logic [7:0] v;
        csr_rd(v);
        chk("read_clear", "value read (R3)", {24'b0, v}, 32'h0B);
        chk("read_clear", "status cleared (R4)", {31'b0, csr_rdata[0]}, 0);
        chk("read_clear", "irq dropped (R4)", {31'b0, irq}, 0);
    endtask

    task automatic t_rewrite;
        csr_wr(8'h0A);
        repeat (3) @(negedge clk);
        chk("rewrite", "no start from level (R1)", {31'b0, csr_rdata[2]}, 0);
        csr_wr(8'h00);
        chk("rewrite", "start bit cleared (R3)", {24'b0, csr_rdata}, 0);
    endtask

    task automatic t_long_field1;
        logic [7:0] v;
        load(1);
        send_frame("long_f1", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("long_f1", "status kept on coincident read (R4)", {31'b0, csr_rdata[0]}, 1);
        csr_rd(v);
        csr_wr(8'h00);
        chk("long_f1", "status cleared later (R4)", {31'b0, csr_rdata[0]}, 0);
    endtask

    task automatic t_busy_meddle;
        logic [7:0] v;
        load(2);
        send_frame("busy_meddle", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk("busy_meddle", "no relaunch after start while busy (R1)", {31'b0, csr_rdata[2]}, 0);
        csr_rd(v);
        csr_wr(8'h00);
        // buffer must still hold the original byte 5 (R10)
        send_frame("buf_check_R10", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        csr_rd(v);
        csr_wr(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        t_reset();
        t_short_ones();
        t_read_clear();
        t_rewrite();
        t_long_field1();
        t_busy_meddle();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule